// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block gathers up to 128 level-sensitive interrupt sources into banks of 32. Software reaches it through a plain 32-bit register bus. Each source can be raised by its input pin or by a software bit. Each source can also be masked, and each is routed either to the normal request line (IRQ) or to the fast request line (FIQ).

Each source carries a 6-bit urgency value. For each request line, the controller picks the most urgent unmasked pending source and latches its number into an active-vector register. That choice stays frozen until software writes an acknowledge bit. The controller then takes the next winner one cycle later. The request outputs themselves follow the pending state directly, with no register in the path.

A handler typically works in this order:

1. Read the active vector.
2. Service the device.
3. Write the acknowledge bit.
4. Adjust the masks if the interrupt level is to be changed.

A software-controlled reset returns the masks, the routing and urgency settings, and the software bits to their power-up values.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every mask bit reads 1, every level register reads 0, every software bit reads 0, `irq_o` and `fiq_o` are low, and both active-vector registers read 0x80.
- R2: Source n belongs to bank n>>5, bit n&31. A source is pending when (input OR software bit) AND NOT mask. A masked source does not drive either output. For bank b the registers sit at base 0x80+0x20*b: +0x00 reads the raw inputs, +0x18 reads the pending IRQ-routed sources, and +0x1C reads the pending FIQ-routed sources.
- R3: Bank offset +0x04 is the mask register and is read/write, with 1 meaning blocked. Writing to +0x08 clears each mask bit written as 1, and writing to +0x0C sets each mask bit written as 1. All three offsets read back the mask.
- R4: Writing 1s to bank offset +0x10 sets software bits, and writing 1s to +0x14 clears them. Both offsets read back the software bits.
- R5: Source n has a level register at 0x100+4n. Bit 0 routes the source to FIQ when 1 and to IRQ when 0. Bits 7:2 hold the urgency value, and reads return this same layout.
- R6: Among pending sources of one route, the lowest urgency value wins. When two sources tie, the lower source number wins.
- R7: Offsets 0x40 (IRQ) and 0x44 (FIQ) return the active source number. The number is captured on the clock edge after its source becomes pending, and it stays frozen until that route is acknowledged, even if the source goes away.
- R8: A write to 0x48 with bit 0 set acknowledges IRQ, and a write with bit 1 set acknowledges FIQ. The current winner is captured on the following edge. An acknowledge on one route leaves the other route alone.
- R9: When no source of a route is pending and that route is not frozen, its active-vector register reads 0x80 (bit 7 flags spurious).
- R10: `irq_o` (`fiq_o`) is high in the same cycle that any IRQ-routed (FIQ-routed) source is pending.
- R11: At 0x10, bit 0 is a read/write auto-idle flag and writing bit 1 performs a soft reset with the effect of R1. Offset 0x14 reads 1 (reset complete), and offset 0x00 reads the `REV` parameter as a major/minor nibble pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_i | input | NUM_SRC | Level-sensitive interrupt inputs |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest situation to reach is the frozen vector. Several sources of different urgency must be pending together, and the latched number has to stay put while better candidates come and go. The bench gets there in three steps:

1. It programs the urgency values first.
2. It raises four inputs in a single cycle, so arbitration sees all of them at once.
3. It drops the current winner and acknowledges, one source at a time.

This walks the winners in order and exposes the tie between two equal urgency values.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int          NUM_SRC = 128,
  parameter logic [7:0]  REV     = 8'h21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int         NBANK   = NUM_SRC / 32;
  localparam logic [7:0] SPUR    = 8'h80;
  localparam logic [11:0] LVL_END = 12'(256 + 4 * NUM_SRC);

  logic [NUM_SRC-1:0] mask_q, swi_q, fsel_q;
  logic [5:0]         pri_q [NUM_SRC];
  logic               idle_q, hold_irq_q, hold_fiq_q;
  logic [7:0]         act_irq_q, act_fiq_q;

  wire       aligned  = bus_addr[1:0] == 2'b00;
  wire       soft_rst = bus_we && bus_addr == 12'h010 && bus_wdata[1];
  wire       ack_irq  = bus_we && bus_addr == 12'h048 && bus_wdata[0];
  wire       ack_fiq  = bus_we && bus_addr == 12'h048 && bus_wdata[1];
  wire       bank_hit = aligned && bus_addr[11:7] == 5'b00001;
  wire [1:0] bsel     = bus_addr[6:5];
  wire [2:0] breg     = bus_addr[4:2];
  wire       lvl_hit  = aligned && bus_addr >= 12'h100 && bus_addr < LVL_END;
  wire [6:0] lidx     = 7'(bus_addr[9:2] - 8'd64);

  wire [NUM_SRC-1:0] pend     = (src_i | swi_q) & ~mask_q;
  wire [NUM_SRC-1:0] pend_irq = pend & ~fsel_q;
  wire [NUM_SRC-1:0] pend_fiq = pend & fsel_q;

  assign irq_o = |pend_irq;
  assign fiq_o = |pend_fiq;

  logic [6:0] win_irq, win_fiq;
  logic [5:0] best_irq, best_fiq;
  logic       any_irq, any_fiq;

  always_comb begin
    win_irq = '0; best_irq = 6'h3f; any_irq = 1'b0;
    win_fiq = '0; best_fiq = 6'h3f; any_fiq = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_irq[i] && (!any_irq || pri_q[i] < best_irq)) begin
        any_irq = 1'b1; best_irq = pri_q[i]; win_irq = 7'(i);
      end
      if (pend_fiq[i] && (!any_fiq || pri_q[i] < best_fiq)) begin
        any_fiq = 1'b1; best_fiq = pri_q[i]; win_fiq = 7'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1; swi_q <= '0; fsel_q <= '0;
      for (int i = 0; i < NUM_SRC; i++) pri_q[i] <= '0;
    end else if (soft_rst) begin
      mask_q <= '1; swi_q <= '0; fsel_q <= '0;
      for (int i = 0; i < NUM_SRC; i++) pri_q[i] <= '0;
    end else begin
      if (bank_hit && bus_we) begin
        for (int b = 0; b < NBANK; b++) begin
          if (bsel == 2'(b)) begin
            case (breg)
              3'd1: mask_q[b*32 +: 32] <= bus_wdata;
              3'd2: mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] & ~bus_wdata;
              3'd3: mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] | bus_wdata;
              3'd4: swi_q[b*32 +: 32]  <= swi_q[b*32 +: 32] | bus_wdata;
              3'd5: swi_q[b*32 +: 32]  <= swi_q[b*32 +: 32] & ~bus_wdata;
              default: ;
            endcase
          end
        end
      end
      if (lvl_hit && bus_we) begin
        fsel_q[lidx] <= bus_wdata[0];
        pri_q[lidx]  <= bus_wdata[7:2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            idle_q <= 1'b0;
    else if (bus_we && bus_addr == 12'h010) idle_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_irq_q <= SPUR; hold_irq_q <= 1'b0;
      act_fiq_q <= SPUR; hold_fiq_q <= 1'b0;
    end else begin
      if (ack_irq || soft_rst) hold_irq_q <= 1'b0;
      else if (!hold_irq_q) begin
        act_irq_q  <= any_irq ? {1'b0, win_irq} : SPUR;
        hold_irq_q <= any_irq;
      end
      if (ack_fiq || soft_rst) hold_fiq_q <= 1'b0;
      else if (!hold_fiq_q) begin
        act_fiq_q  <= any_fiq ? {1'b0, win_fiq} : SPUR;
        hold_fiq_q <= any_fiq;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bank_hit) begin
      for (int b = 0; b < NBANK; b++) begin
        if (bsel == 2'(b)) begin
          case (breg)
            3'd0:          bus_rdata = src_i[b*32 +: 32];
            3'd1,3'd2,3'd3: bus_rdata = mask_q[b*32 +: 32];
            3'd4,3'd5:     bus_rdata = swi_q[b*32 +: 32];
            3'd6:          bus_rdata = pend_irq[b*32 +: 32];
            default:       bus_rdata = pend_fiq[b*32 +: 32];
          endcase
        end
      end
    end else if (lvl_hit) begin
      bus_rdata = {24'b0, pri_q[lidx], 1'b0, fsel_q[lidx]};
    end else begin
      case (bus_addr)
        12'h000: bus_rdata = {24'b0, REV};
        12'h010: bus_rdata = {31'b0, idle_q};
        12'h014: bus_rdata = 32'd1;
        12'h040: bus_rdata = {24'b0, act_irq_q};
        12'h044: bus_rdata = {24'b0, act_fiq_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_IRQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_irq_q && !ack_irq && !soft_rst |=> $stable(act_irq_q)); // R7
  AST_FIQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_fiq_q && !ack_fiq && !soft_rst |=> $stable(act_fiq_q)); // R7
  AST_IRQ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_irq_q && irq_o && !ack_irq && !soft_rst |=> !act_irq_q[7] && hold_irq_q); // R7
  AST_IRQ_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_irq_q && !irq_o && !ack_irq && !soft_rst |=> act_irq_q == SPUR); // R9
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_irq |=> !hold_irq_q); // R8
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (&mask_q) && swi_q == '0 && fsel_q == '0); // R11
endmodule

// File: tb/banked_irq_ctrl_tb_top.sv
module banked_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] src = '0;
  logic         irq_o, fiq_o;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src),
    .irq_o(irq_o), .fiq_o(fiq_o));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk); bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 mask bank0", 12'h084, 32'hFFFFFFFF);
    rd_chk("R1 mask bank3", 12'h0E4, 32'hFFFFFFFF);
    rd_chk("R1 level 5", 12'h114, 32'h0);
    rd_chk("R1 irq vector", 12'h040, 32'h80);
    rd_chk("R1 fiq vector", 12'h044, 32'h80);
    chk("R1 irq_o", {31'b0, irq_o}, 32'd0);
    chk("R1 fiq_o", {31'b0, fiq_o}, 32'd0);
    rd_chk("R11 revision", 12'h000, 32'h21);
    rd_chk("R11 sysstatus", 12'h014, 32'h1);
  endtask

  task automatic t_mask;
    @(negedge clk); src[3] = 1'b1;
    rd_chk("R2 raw bank0", 12'h080, 32'h8);
    chk("R2 masked irq_o", {31'b0, irq_o}, 32'd0);
    rd_chk("R2 masked pending", 12'h098, 32'h0);
    rd_chk("R9 vector idle", 12'h040, 32'h80);
    wr(12'h088, 32'h8);
    rd_chk("R3 mask clear alias", 12'h084, 32'hFFFFFFF7);
    chk("R10 irq_o up", {31'b0, irq_o}, 32'd1);
    rd_chk("R2 pending irq", 12'h098, 32'h8);
    rd_chk("R7 vector captured", 12'h040, 32'd3);
    wr(12'h048, 32'h1);
    rd_chk("R8 recapture same", 12'h040, 32'd3);
    @(negedge clk); src[3] = 1'b0; #1;
    chk("R10 irq_o down", {31'b0, irq_o}, 32'd0);
    wr(12'h08C, 32'h8);
    rd_chk("R3 mask set alias", 12'h08C, 32'hFFFFFFFF);
    rd_chk("R7 frozen after drop", 12'h040, 32'd3);
    wr(12'h048, 32'h1);
    rd_chk("R9 spurious after ack", 12'h040, 32'h80);
  endtask

  task automatic t_priority;
    for (int b = 0; b < 4; b++) wr(12'(12'h088 + 32 * b), 32'hFFFFFFFF);
    wr(12'h104, 32'(2 << 2));
    wr(12'h1A0, 32'(2 << 2));
    wr(12'h218, 32'(9 << 2));
    wr(12'h290, 32'(1 << 2));
    rd_chk("R5 level readback", 12'h218, 32'h24);
    @(negedge clk); src[1] = 1'b1; src[40] = 1'b1; src[70] = 1'b1; src[100] = 1'b1;
    rd_chk("R2 pending bank2", 12'h0D8, 32'h40);
    rd_chk("R6 most urgent first", 12'h040, 32'd100);
    @(negedge clk); src[100] = 1'b0;
    wr(12'h048, 32'h1);
    rd_chk("R6 tie lower number", 12'h040, 32'd1);
    @(negedge clk); src[1] = 1'b0;
    wr(12'h048, 32'h1);
    rd_chk("R6 next winner", 12'h040, 32'd40);
    @(negedge clk); src[40] = 1'b0;
    wr(12'h048, 32'h1);
    rd_chk("R6 least urgent last", 12'h040, 32'd70);
    @(negedge clk); src[70] = 1'b0;
    wr(12'h048, 32'h1);
    rd_chk("R9 drained", 12'h040, 32'h80);
  endtask

  task automatic t_fiq;
    wr(12'h184, 32'h1);
    wr(12'h0B0, 32'h2);
    chk("R10 fiq_o up", {31'b0, fiq_o}, 32'd1);
    chk("R5 irq_o stays low", {31'b0, irq_o}, 32'd0);
    rd_chk("R2 pending irq bank1", 12'h0B8, 32'h0);
    rd_chk("R2 pending fiq bank1", 12'h0BC, 32'h2);
    rd_chk("R7 fiq vector", 12'h044, 32'd33);
    rd_chk("R5 irq vector idle", 12'h040, 32'h80);
    rd_chk("R4 swi set read", 12'h0B0, 32'h2);
    rd_chk("R4 swi clear read", 12'h0B4, 32'h2);
    wr(12'h048, 32'h1);
    rd_chk("R8 irq ack leaves fiq", 12'h044, 32'd33);
    wr(12'h0B4, 32'h2);
    chk("R4 fiq_o after clear", {31'b0, fiq_o}, 32'd0);
    rd_chk("R4 swi cleared", 12'h0B0, 32'h0);
    rd_chk("R7 fiq frozen", 12'h044, 32'd33);
    wr(12'h048, 32'h2);
    rd_chk("R8 fiq ack", 12'h044, 32'h80);
  endtask

  task automatic t_soft;
    wr(12'h0D0, 32'h20);
    wr(12'h010, 32'h3);
    rd_chk("R11 masks restored", 12'h084, 32'hFFFFFFFF);
    rd_chk("R11 bank2 mask", 12'h0C4, 32'hFFFFFFFF);
    rd_chk("R11 level cleared", 12'h184, 32'h0);
    rd_chk("R11 swi cleared", 12'h0D0, 32'h0);
    rd_chk("R11 autoidle", 12'h010, 32'h1);
    rd_chk("R11 status", 12'h014, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_priority();
    t_fiq();
    t_soft();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule